// File: doc/BRIEF.md
# Banked-Register GPIO Controller with Edge Interrupts

This block is a 48-line general-purpose I/O controller that sits on a byte-wide host bus. The bus has a 4-bit address, a write strobe and a read strobe. The lines form six 8-bit ports. Each port has an output latch, which the host can only write. A read of the port returns the pin levels after synchronization. To use a line as an input, the host writes 0 to its output bit, so the output does not pull the pin. A read then shows the external level.

The lines of the first three ports (lines 0 to 23) can record an edge event. For each line the host sets an enable bit and a polarity bit: 1 selects the rising edge and 0 selects the falling edge. The enable masks, the polarity masks and the latched event bits share three bank addresses. A page register chooses which of the three sets those addresses reach.

A summary register has one flag for each interrupt-capable port. The active-high `irq` output is the OR of those flags. There is no write-one-to-clear. The host acknowledges an event by writing its enable bit to 0 and then back to 1.

Top module: `gpio_bank48`

## Requirements
- R1: A write to offset n (0 to 5) loads the output latch of port n, which drives `pin_out[8n+7:8n]`. A read of offset n returns `pin_in[8n+7:8n]` as it was sampled two clocks earlier.
- R2: After reset, all output latches, enable masks, polarity masks and event bits are 0, and `irq` is 0. The page register holds the status page, so a read of offset 7 returns 0xC0.
- R3: An enabled line with polarity bit 1 latches its event bit on a low-to-high transition of its synchronized input.
- R4: An enabled line with polarity bit 0 latches its event bit on a high-to-low transition. The opposite edge latches nothing.
- R5: A line whose enable bit is 0 never latches an event. Activity on lines 24 to 47 never affects `irq` or the summary register.
- R6: Offset 6 reads back with bit p set when port p (0 to 2) has any latched event bit, and with bits 7:3 equal to 0. `irq` is high exactly when that value is non-zero.
- R7: Writing an enable bit to 0 clears that line's event bit. Writing it back to 1 re-arms the line without creating an event.
- R8: Writing offset 7 with 0x80 selects the enable page, with 0x40 the polarity page, and with 0xC0 the status page. Any other value leaves the page unchanged. A read of offset 7 returns the code of the current page.
- R9: Offsets 8, 9 and 10 reach ports 0, 1 and 2 in the current page. On the enable and polarity pages they can be written and read back. On the status page they return the event bits, and writes to them are ignored.
- R10: Reads of offsets 11 to 15 return 0. Writes to those offsets change no latch, mask or page.
- R11: An event bit stays set after its pin returns to its former level, until the line is acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 4 | Byte offset of the register being accessed |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe; the write takes effect on the rising clock edge |
| rd_en | input | 1 | Read strobe; `rdata` is 0 when this is low |
| rdata | output | 8 | Read data, combinational from `addr` |
| pin_in | input | 48 | External pin levels |
| pin_out | output | 48 | Output latch contents |
| irq | output | 1 | Combined interrupt, active high |

## Verification
The bench first raises and drops a line with the wrong polarity. A design that detects both edges, or that inverts the polarity sense, would latch an event there. After an event it returns the pin to its former level and requires the bit to stay set. It then lowers and restores the enable bit and checks that the bit clears without being set again. A design that treated the re-arm as a new edge would leave `irq` high.

It writes page codes outside the three valid ones and requires the page to stay where it was. It also writes the bank addresses while the status page is selected. A careless decoder would let such a write corrupt the enable mask.

It also toggles ports 3 to 5 and writes the unused offsets. A decoder that aliases addresses would raise `irq` or change a latch.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned ADDR_W = 4;
  localparam int unsigned BYTE_W = 8;

  localparam logic [ADDR_W-1:0] OFS_SUMMARY = 4'd6;
  localparam logic [ADDR_W-1:0] OFS_PAGE    = 4'd7;
  localparam logic [ADDR_W-1:0] OFS_BANK0   = 4'd8;

  localparam logic [BYTE_W-1:0] CODE_ENABLE   = 8'h80;
  localparam logic [BYTE_W-1:0] CODE_POLARITY = 8'h40;
  localparam logic [BYTE_W-1:0] CODE_STATUS   = 8'hC0;

  typedef enum logic [1:0] {
    PG_ENABLE   = 2'd1,
    PG_POLARITY = 2'd2,
    PG_STATUS   = 2'd3
  } page_e;

  function automatic logic page_code_valid(input logic [BYTE_W-1:0] c);
    return (c == CODE_ENABLE) || (c == CODE_POLARITY) || (c == CODE_STATUS);
  endfunction

  function automatic page_e page_decode(input logic [BYTE_W-1:0] c);
    if (c == CODE_ENABLE)   return PG_ENABLE;
    if (c == CODE_POLARITY) return PG_POLARITY;
    return PG_STATUS;
  endfunction

  function automatic logic [BYTE_W-1:0] page_encode(input page_e p);
    case (p)
      PG_ENABLE:   return CODE_ENABLE;
      PG_POLARITY: return CODE_POLARITY;
      default:     return CODE_STATUS;
    endcase
  endfunction

  // Per-bit edge match: polarity 1 = rising, 0 = falling, gated by enable.
  function automatic logic [BYTE_W-1:0] edge_hits(
    input logic [BYTE_W-1:0] cur,
    input logic [BYTE_W-1:0] prev,
    input logic [BYTE_W-1:0] pol,
    input logic [BYTE_W-1:0] en
  );
    logic [BYTE_W-1:0] rise;
    logic [BYTE_W-1:0] fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    return en & ((pol & rise) | (~pol & fall));
  endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 48,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else if (s == 0) chain[s] <= d;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] pin_s,
  input  logic              en_we,
  input  logic              pol_we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] en_q,
  output logic [BYTE_W-1:0] pol_q,
  output logic [BYTE_W-1:0] status_q,
  output logic              flag
);
  logic [BYTE_W-1:0] prev_q;
  logic [BYTE_W-1:0] hits;
  logic [BYTE_W-1:0] en_next;

  assign hits    = edge_hits(pin_s, prev_q, pol_q, en_q);
  assign en_next = en_we ? wdata : en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      en_q     <= '0;
      pol_q    <= '0;
      status_q <= '0;
    end else begin
      prev_q   <= pin_s;
      en_q     <= en_next;
      if (pol_we) pol_q <= wdata;
      // A dropped enable bit clears its event; a raised one starts empty.
      status_q <= (status_q | hits) & en_next;
    end
  end

  assign flag = |status_q;

  // R3/R4: a matching edge is latched on the next cycle when no enable write intervenes.
  p_edge_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_we && hits != '0) |=> ((status_q & $past(hits)) == $past(hits)));

  // R7: after an enable write, no event remains on a line written to 0.
  p_ack_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> ((status_q & ~$past(wdata)) == '0));

  // R5: an event bit is never set on a disabled line.
  p_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q & ~en_q) == '0);

  // R11: with no enable write, a set event bit stays set.
  p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en_we |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/gpio_bank48.sv
module gpio_bank48
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 6,
  parameter int unsigned IRQ_PORTS   = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [BYTE_W-1:0]           wdata,
  input  logic                        wr_en,
  input  logic                        rd_en,
  output logic [BYTE_W-1:0]           rdata,
  input  logic [NUM_PORTS*BYTE_W-1:0] pin_in,
  output logic [NUM_PORTS*BYTE_W-1:0] pin_out,
  output logic                        irq
);
  localparam int unsigned LINES = NUM_PORTS * BYTE_W;

  logic [LINES-1:0]     pin_s;
  logic [BYTE_W-1:0]    out_q    [NUM_PORTS];
  logic [BYTE_W-1:0]    en_q     [IRQ_PORTS];
  logic [BYTE_W-1:0]    pol_q    [IRQ_PORTS];
  logic [BYTE_W-1:0]    status_q [IRQ_PORTS];
  logic [IRQ_PORTS-1:0] flags;
  logic [IRQ_PORTS-1:0] bank_en_we;
  logic [IRQ_PORTS-1:0] bank_pol_we;
  logic                 page_we;
  page_e                page_q;

  gpio_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s)
  );

  // Output latches, one per port.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q[p] <= '0;
      else if (wr_en && addr == ADDR_W'(p)) out_q[p] <= wdata;
    end
    assign pin_out[p*BYTE_W +: BYTE_W] = out_q[p];
  end

  // Page select; unknown codes are discarded.
  assign page_we = wr_en && addr == OFS_PAGE && page_code_valid(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) page_q <= PG_STATUS;
    else if (page_we) page_q <= page_decode(wdata);
  end

  // Banked per-port interrupt logic.
  for (genvar b = 0; b < IRQ_PORTS; b++) begin : g_bank
    logic hit_addr;
    assign hit_addr       = wr_en && addr == (OFS_BANK0 + ADDR_W'(b));
    assign bank_en_we[b]  = hit_addr && page_q == PG_ENABLE;
    assign bank_pol_we[b] = hit_addr && page_q == PG_POLARITY;

    gpio_edge_port u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_s    (pin_s[b*BYTE_W +: BYTE_W]),
      .en_we    (bank_en_we[b]),
      .pol_we   (bank_pol_we[b]),
      .wdata    (wdata),
      .en_q     (en_q[b]),
      .pol_q    (pol_q[b]),
      .status_q (status_q[b]),
      .flag     (flags[b])
    );
  end

  assign irq = |flags;

  // Read multiplexer.
  always_comb begin
    rdata = '0;
    if (rd_en) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (addr == ADDR_W'(p)) rdata = pin_s[p*BYTE_W +: BYTE_W];
      end
      if (addr == OFS_SUMMARY) rdata[IRQ_PORTS-1:0] = flags;
      if (addr == OFS_PAGE)    rdata = page_encode(page_q);
      for (int b = 0; b < IRQ_PORTS; b++) begin
        if (addr == (OFS_BANK0 + ADDR_W'(b))) begin
          case (page_q)
            PG_ENABLE:   rdata = en_q[b];
            PG_POLARITY: rdata = pol_q[b];
            default:     rdata = status_q[b];
          endcase
        end
      end
    end
  end

  // R8: a write of an invalid code to the page register keeps the page.
  p_page_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_PAGE && !page_code_valid(wdata)) |=> $stable(page_q));

  // R9: no bank register changes from a write while the status page is selected.
  p_status_page_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && page_q == PG_STATUS) |=> ($stable(en_q[0]) && $stable(pol_q[0])));

  // R6: the interrupt is high only when some event bit is latched.
  p_irq_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((status_q[0] | status_q[1] | status_q[2]) != '0));

  // R10: a write to an unused offset leaves every output latch alone.
  p_unused_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr > (OFS_BANK0 + ADDR_W'(IRQ_PORTS - 1))) |=> $stable(pin_out));
endmodule

// File: tb/gpio_bank48_tb.sv
module gpio_bank48_tb_top;
  localparam time CLK_P = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rdata;
  logic [47:0] pin_in = '0;
  logic [47:0] pin_out;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  gpio_bank48 dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .irq(irq)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1;
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R2 pin_out", pin_out, 48'h0);
    check("R2 irq", irq, 0);
    rd(4'd7, d); check("R2 page", d, 8'hC0);
    rd(4'd6, d); check("R2 summary", d, 8'h00);
    rd(4'd8, d); check("R2 status", d, 8'h00);
    wr(4'd7, 8'h80);
    rd(4'd9, d); check("R2 enable mask", d, 8'h00);
    wr(4'd7, 8'h40);
    rd(4'd10, d); check("R2 polarity mask", d, 8'h00);
    wr(4'd7, 8'hC0);
  endtask

  task automatic t_ports();
    logic [7:0] d;
    wr(4'd0, 8'hA5);
    wr(4'd5, 8'h3C);
    check("R1 latch port0", pin_out[7:0], 8'hA5);
    check("R1 latch port5", pin_out[47:40], 8'h3C);
    pin_in[15:8] = 8'h5A;
    pin_in[39:32] = 8'hC3;
    settle();
    rd(4'd1, d); check("R1 read port1", d, 8'h5A);
    rd(4'd4, d); check("R1 read port4", d, 8'hC3);
    pin_in = '0;
    settle();
  endtask

  task automatic t_rise();
    logic [7:0] d;
    wr(4'd7, 8'h80); wr(4'd8, 8'h01); wr(4'd9, 8'h08);
    wr(4'd7, 8'h40); wr(4'd8, 8'h01);
    wr(4'd7, 8'hC0);
    settle();
    pin_in[0] = 1'b1;
    settle();
    rd(4'd8, d); check("R3 rise latched", d, 8'h01);
    check("R6 irq on event", irq, 1);
    rd(4'd6, d); check("R6 summary port0", d, 8'h01);
    pin_in[0] = 1'b0;
    settle();
    rd(4'd8, d); check("R11 sticky after fall", d, 8'h01);
  endtask

  task automatic t_fall();
    logic [7:0] d;
    pin_in[11] = 1'b1;
    settle();
    rd(4'd9, d); check("R4 rise ignored", d, 8'h00);
    pin_in[11] = 1'b0;
    settle();
    rd(4'd9, d); check("R4 fall latched", d, 8'h08);
    rd(4'd6, d); check("R6 summary two ports", d, 8'h03);
  endtask

  task automatic t_ack();
    logic [7:0] d;
    wr(4'd7, 8'h80); wr(4'd8, 8'h00);
    wr(4'd7, 8'hC0);
    rd(4'd8, d); check("R7 cleared by disable", d, 8'h00);
    rd(4'd6, d); check("R7 summary after clear", d, 8'h02);
    wr(4'd7, 8'h80); wr(4'd8, 8'h01); wr(4'd9, 8'h00); wr(4'd9, 8'h08);
    wr(4'd7, 8'hC0);
    settle();
    rd(4'd8, d); check("R7 re-arm adds no event", d, 8'h00);
    rd(4'd9, d); check("R7 port1 acknowledged", d, 8'h00);
    check("R6 irq low after ack", irq, 0);
    pin_in[0] = 1'b1;
    settle();
    rd(4'd8, d); check("R7 re-armed line fires", d, 8'h01);
    wr(4'd7, 8'h80); wr(4'd8, 8'h00); wr(4'd8, 8'h01);
    wr(4'd7, 8'hC0);
  endtask

  task automatic t_disabled();
    logic [7:0] d;
    pin_in[17] = 1'b1; settle();
    pin_in[17] = 1'b0; settle();
    rd(4'd10, d); check("R5 disabled line", d, 8'h00);
    pin_in[47:24] = 24'hFFFFFF; settle();
    pin_in[47:24] = 24'h000000; settle();
    check("R5 upper ports no irq", irq, 0);
    rd(4'd6, d); check("R5 summary untouched", d, 8'h00);
  endtask

  task automatic t_page();
    logic [7:0] d;
    wr(4'd7, 8'h80);
    rd(4'd7, d); check("R8 enable code", d, 8'h80);
    rd(4'd8, d); check("R9 enable readback", d, 8'h01);
    wr(4'd7, 8'h12);
    rd(4'd7, d); check("R8 bad code holds", d, 8'h80);
    wr(4'd7, 8'h40);
    rd(4'd8, d); check("R9 polarity readback", d, 8'h01);
    wr(4'd7, 8'hC0);
    wr(4'd8, 8'hFF);
    wr(4'd7, 8'h80);
    rd(4'd8, d); check("R9 status page write ignored", d, 8'h01);
    wr(4'd7, 8'hC0);
  endtask

  task automatic t_unused();
    logic [7:0] d;
    for (int a = 11; a < 16; a++) wr(4'(a), 8'hFF);
    for (int a = 11; a < 16; a++) begin
      rd(4'(a), d); check("R10 unused read", d, 8'h00);
    end
    rd(4'd7, d); check("R10 page unchanged", d, 8'hC0);
    check("R10 latches unchanged", pin_out, 48'h3C00000000A5);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ports();
    t_rise();
    t_fall();
    t_ack();
    t_disabled();
    t_page();
    t_unused();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule